// File: doc/BRIEF.md
# Link Hot Reset State Controller

This block runs the hot-reset phase of one serial link port's training state machine. The port is built either as downstream-facing (toward the subordinate device) or as upstream-facing (toward the host), and that choice changes how the port leaves the phase. The decoder in front of the block gives it one strobe per received training set. With each strobe it passes two flags: the set carries the hot-reset request, and the set's link and lane numbers equal the configured ones. A higher layer can hold the port in hot reset, which is what the bridge-control reset bit does. A separate entry trigger starts the phase from Idle or Detect.

While in the phase, the port asks its transmitter for hot-reset training sets on every cycle. A run of consecutive qualifying sets (two by default) counts as confirmation from the link partner and drops LinkUp. A downstream-facing port with no hold active takes that confirmation as leave to exit early. Without confirmation the port falls back to a cycle-count timeout, which stands for the 2 ms interval in silicon. The timeout is reloaded on entry and on every cycle the hold is active. An upstream-facing port never exits early: each qualifying pair reloads its timeout, and it leaves only after a full quiet interval. Software holding the reset bit should keep it set for at least 1 ms, and 2 ms is the margin normally used. The block itself only reacts to the level of the hold input.

Top module: `hot_reset_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `state_o` is 0 (Idle), `tx_hot_ts` and `detect_pulse` are 0, and `link_up` equals `LINKUP_RST` (1 by default).
- R2: When `enter_req` is high in Idle (0) or Detect (2), `state_o` reads 1 (Hot Reset) on the next cycle, and `tx_hot_ts` is high on every cycle with `state_o` = 1.
- R3: A qualifying set is a cycle with `ts_valid`, `ts_hot` and `ts_match` all high. `PAIR_LEN` consecutive qualifying sets form a pair. A valid set lacking `ts_hot` or `ts_match` restarts the count, cycles with `ts_valid` low leave it unchanged, and a completed pair restarts the count for the next one.
- R4: `link_up` goes to 0 on the cycle after a pair completes in Hot Reset and stays 0 until `rst`.
- R5: While `hold_req` is high, the port stays in Hot Reset with `tx_hot_ts` high, whatever pairs arrive and however long the hold lasts.
- R6: A downstream-facing port (`IS_UPSTREAM` = 0) leaves for Detect (2) on the cycle after the first cycle that has `hold_req` low and a pair completed in the current stay, whether the pair arrives in that cycle or earlier. Received pairs never reload its timer.
- R7: The timer loads `TIMEOUT_CYCLES` on entry and on each cycle with `hold_req` high, and it then counts down once per cycle. With no other exit, `state_o` becomes 2 exactly `TIMEOUT_CYCLES`+2 cycles after the last loading cycle.
- R8: An upstream-facing port (`IS_UPSTREAM` = 1) never exits on a pair. The cycle that completes a pair reloads its timer, so it leaves `TIMEOUT_CYCLES`+2 cycles after the last pair.
- R9: `detect_pulse` is high for exactly one cycle, the first cycle of Detect, in which `tx_hot_ts` is already 0.
- R10: `enter_req` during Hot Reset has no effect: it neither reloads the timer nor changes the exit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_valid | input | 1 | A decoded training set arrives this cycle |
| ts_hot | input | 1 | That set carries the hot-reset request |
| ts_match | input | 1 | That set's link and lane numbers equal the configured ones |
| hold_req | input | 1 | Higher layer holds the port in hot reset |
| enter_req | input | 1 | Trigger to enter hot reset |
| tx_hot_ts | output | 1 | Transmit hot-reset training sets |
| link_up | output | 1 | Link-up flag |
| state_o | output | 2 | 0 Idle, 1 Hot Reset, 2 Detect |
| detect_pulse | output | 1 | One-cycle pulse on exit to Detect |

## Verification
Every output of the block comes from a register. A change of state, LinkUp or the exit pulse therefore shows up on the cycle after the input cycle that causes it. A confirmed exit is due one cycle after the deciding pair or the release of the hold. A timeout exit is due `TIMEOUT_CYCLES`+2 cycles after the last cycle that loaded the timer. Inputs change only on falling edges. A behavioural model advances on each rising edge, and the outputs of a downstream-facing and an upstream-facing instance are compared with it on every falling edge. Directed checks also wait the exact number of falling edges worked out above, and check both the cycle just before each exit and the exit cycle itself.

// File: rtl/hrst_pkg.sv
package hrst_pkg;
   typedef enum logic [1:0] {
      HRST_IDLE   = 2'd0,
      HRST_HOT    = 2'd1,
      HRST_DETECT = 2'd2
   } hrst_state_e;
endpackage

// File: rtl/hrst_pair_det.sv
module hrst_pair_det #(
   parameter int PAIR_LEN = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic active,
   input  logic ts_valid,
   input  logic ts_hot,
   input  logic ts_match,
   output logic pair_hit
);
   localparam int CW = $clog2(PAIR_LEN + 1);

   logic [CW-1:0] run_q;
   logic          good;

   assign good     = ts_valid & ts_hot & ts_match;
   assign pair_hit = active & good & (run_q == CW'(PAIR_LEN - 1));

   always_ff @(posedge clk) begin
      if (rst || !active) begin
         run_q <= '0;
      end else if (ts_valid) begin
         if (!(ts_hot && ts_match)) begin
            run_q <= '0;
         end else if (pair_hit) begin
            run_q <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/hrst_timer.sv
module hrst_timer #(
   parameter int TIMEOUT_CYCLES = 500000
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic run,
   output logic expired
);
   localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

   logic [TW-1:0] left_q;

   assign expired = (left_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         left_q <= '0;
      end else if (load) begin
         left_q <= TW'(TIMEOUT_CYCLES);
      end else if (run && !expired) begin
         left_q <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/hrst_fsm.sv
module hrst_fsm
   import hrst_pkg::*;
#(
   parameter bit LINKUP_RST = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        enter_req,
   input  logic        hold_req,
   input  logic        pair_hit,
   input  logic        leave_req,
   output hrst_state_e state,
   output logic        hot,
   output logic        enter_now,
   output logic        confirm_seen,
   output logic        detect_pulse,
   output logic        link_up
);
   logic leave;

   assign hot       = (state == HRST_HOT);
   assign enter_now = !hot && enter_req;
   assign leave     = hot && !hold_req && leave_req;

   always_ff @(posedge clk) begin
      if (rst) begin
         state        <= HRST_IDLE;
         detect_pulse <= 1'b0;
         link_up      <= LINKUP_RST;
         confirm_seen <= 1'b0;
      end else begin
         detect_pulse <= leave;
         if (enter_now) begin
            state <= HRST_HOT;
         end else if (leave) begin
            state <= HRST_DETECT;
         end
         if (pair_hit) begin
            link_up <= 1'b0;
         end
         if (!hot || leave) begin
            confirm_seen <= 1'b0;
         end else if (pair_hit) begin
            confirm_seen <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/hot_reset_ctrl.sv
module hot_reset_ctrl
   import hrst_pkg::*;
#(
   parameter int TIMEOUT_CYCLES = 500000,
   parameter int PAIR_LEN       = 2,
   parameter bit IS_UPSTREAM    = 1'b0,
   parameter bit LINKUP_RST     = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       ts_valid,
   input  logic       ts_hot,
   input  logic       ts_match,
   input  logic       hold_req,
   input  logic       enter_req,
   output logic       tx_hot_ts,
   output logic       link_up,
   output logic [1:0] state_o,
   output logic       detect_pulse
);
   if (TIMEOUT_CYCLES < 1) begin : g_bad_timeout
      $error("TIMEOUT_CYCLES must be at least 1");
   end
   if (PAIR_LEN < 1) begin : g_bad_pair
      $error("PAIR_LEN must be at least 1");
   end

   hrst_state_e state;
   logic hot, enter_now, seen, pair_hit, expired, leave_req, restart, tmr_load;

   if (IS_UPSTREAM) begin : g_up
      assign leave_req = expired & ~pair_hit;
      assign restart   = pair_hit;
   end else begin : g_dn
      assign leave_req = expired | pair_hit | seen;
      assign restart   = 1'b0;
   end

   assign tmr_load = enter_now | (hot & (hold_req | restart));

   hrst_pair_det #(.PAIR_LEN(PAIR_LEN)) u_pair (
      .clk      (clk),
      .rst      (rst),
      .active   (hot),
      .ts_valid (ts_valid),
      .ts_hot   (ts_hot),
      .ts_match (ts_match),
      .pair_hit (pair_hit)
   );

   hrst_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .load    (tmr_load),
      .run     (hot),
      .expired (expired)
   );

   hrst_fsm #(.LINKUP_RST(LINKUP_RST)) u_fsm (
      .clk          (clk),
      .rst          (rst),
      .enter_req    (enter_req),
      .hold_req     (hold_req),
      .pair_hit     (pair_hit),
      .leave_req    (leave_req),
      .state        (state),
      .hot          (hot),
      .enter_now    (enter_now),
      .confirm_seen (seen),
      .detect_pulse (detect_pulse),
      .link_up      (link_up)
   );

   assign tx_hot_ts = hot;
   assign state_o   = state;
endmodule

// File: rtl/hrst_chk.sv
module hrst_chk
   import hrst_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic       ts_valid,
   input logic       ts_hot,
   input logic       ts_match,
   input logic       hold_req,
   input logic       enter_req,
   input logic       tx_hot_ts,
   input logic       link_up,
   input logic [1:0] state_o,
   input logic       detect_pulse
);
   // R9
   pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
      detect_pulse |=> !detect_pulse);

   // R9
   pulse_in_detect_chk: assert property (@(posedge clk) disable iff (rst)
      detect_pulse |-> (state_o == HRST_DETECT && !tx_hot_ts));

   // R4
   linkup_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      !link_up |=> !link_up);

   // R3
   linkup_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(link_up) |-> $past(ts_valid && ts_hot && ts_match));

   // R5
   hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
      (state_o == HRST_HOT && hold_req) |=> (state_o == HRST_HOT));

   // R2
   tx_start_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_hot_ts) |-> $past(enter_req));
endmodule

bind hot_reset_ctrl hrst_chk u_chk (
   .clk          (clk),
   .rst          (rst),
   .ts_valid     (ts_valid),
   .ts_hot       (ts_hot),
   .ts_match     (ts_match),
   .hold_req     (hold_req),
   .enter_req    (enter_req),
   .tx_hot_ts    (tx_hot_ts),
   .link_up      (link_up),
   .state_o      (state_o),
   .detect_pulse (detect_pulse)
);

// File: tb/tb_hot_reset_ctrl.sv
`timescale 1ns/1ps
module tb_hot_reset_ctrl;
   localparam int T = 20;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ts_valid = 1'b0, ts_hot = 1'b0, ts_match = 1'b0;
   logic hold_req = 1'b0, enter_req = 1'b0;
   logic       tx_d, lu_d, ex_d, tx_u, lu_u, ex_u;
   logic [1:0] st_d, st_u;

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   hot_reset_ctrl #(.TIMEOUT_CYCLES(T), .IS_UPSTREAM(1'b0)) dut (
      .clk(clk), .rst(rst), .ts_valid(ts_valid), .ts_hot(ts_hot),
      .ts_match(ts_match), .hold_req(hold_req), .enter_req(enter_req),
      .tx_hot_ts(tx_d), .link_up(lu_d), .state_o(st_d), .detect_pulse(ex_d));

   hot_reset_ctrl #(.TIMEOUT_CYCLES(T), .IS_UPSTREAM(1'b1)) dut_up (
      .clk(clk), .rst(rst), .ts_valid(ts_valid), .ts_hot(ts_hot),
      .ts_match(ts_match), .hold_req(hold_req), .enter_req(enter_req),
      .tx_hot_ts(tx_u), .link_up(lu_u), .state_o(st_u), .detect_pulse(ex_u));

   // behavioural reference, index 0 = downstream-facing, 1 = upstream-facing
   int m_st[2], m_tmr[2], m_run[2], m_seen[2], m_lu[2], m_ex[2];

   always @(posedge clk) begin
      cyc++;
      for (int u = 0; u < 2; u++) begin
         bit good, pair, go;
         good = ts_valid && ts_hot && ts_match;
         if (rst) begin
            m_st[u] = 0; m_tmr[u] = 0; m_run[u] = 0;
            m_seen[u] = 0; m_lu[u] = 1; m_ex[u] = 0;
         end else begin
            m_ex[u] = 0;
            if (m_st[u] == 1) begin
               pair = good && (m_run[u] == 1);
               if (ts_valid) m_run[u] = (good && !pair) ? m_run[u] + 1 : 0;
               if (pair) m_lu[u] = 0;
               if (u == 0) go = !hold_req && (pair || m_seen[u] != 0 || m_tmr[u] == 0);
               else        go = !hold_req && !pair && m_tmr[u] == 0;
               if (go) begin
                  m_st[u] = 2; m_ex[u] = 1; m_seen[u] = 0; m_run[u] = 0;
               end else begin
                  if (pair) m_seen[u] = 1;
                  if (hold_req || (u == 1 && pair)) m_tmr[u] = T;
                  else if (m_tmr[u] > 0) m_tmr[u] = m_tmr[u] - 1;
               end
            end else if (enter_req) begin
               m_st[u] = 1; m_tmr[u] = T; m_run[u] = 0; m_seen[u] = 0;
            end
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (!rst) begin
         chk("R2", "down state", st_d, m_st[0]);
         chk("R2", "down tx", tx_d, m_st[0] == 1);
         chk("R4", "down link_up", lu_d, m_lu[0]);
         chk("R9", "down pulse", ex_d, m_ex[0]);
         chk("R8", "up state", st_u, m_st[1]);
         chk("R2", "up tx", tx_u, m_st[1] == 1);
         chk("R4", "up link_up", lu_u, m_lu[1]);
         chk("R9", "up pulse", ex_u, m_ex[1]);
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send(input bit v, input bit h, input bit m);
      ts_valid = v; ts_hot = h; ts_match = m;
      @(negedge clk);
      ts_valid = 1'b0; ts_hot = 1'b0; ts_match = 1'b0;
   endtask

   task automatic enter();
      enter_req = 1'b1;
      @(negedge clk);
      enter_req = 1'b0;
   endtask

   initial begin
      tick(3);
      chk("R1", "reset state", st_d, 0);
      chk("R1", "reset tx", tx_d, 0);
      chk("R1", "reset pulse", ex_d, 0);
      chk("R1", "reset link_up", lu_d, 1);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "state after reset", st_u, 0);
      chk("R1", "link_up after reset", lu_u, 1);

      // early exit on a pair; broken and gapped sequences
      enter();
      chk("R2", "entered hot", st_d, 1);
      chk("R2", "tx on entry", tx_d, 1);
      send(1, 1, 1);
      send(1, 1, 0);
      send(1, 1, 1);
      chk("R3", "broken pair keeps hot", st_d, 1);
      chk("R3", "no link drop on broken pair", lu_d, 1);
      send(0, 0, 0);
      send(1, 1, 1);
      chk("R6", "down exit after pair", st_d, 2);
      chk("R9", "pulse on exit", ex_d, 1);
      chk("R9", "tx dropped at exit", tx_d, 0);
      chk("R4", "link_up dropped", lu_d, 0);
      chk("R8", "up stays hot on pair", st_u, 1);
      tick(1);
      chk("R9", "pulse single", ex_d, 0);
      tick(T + 4);
      chk("R8", "up left after timeout", st_u, 2);

      // silent link timeout, with an ignored entry trigger
      enter();
      tick(5);
      enter();
      chk("R10", "enter in hot ignored", st_d, 1);
      tick(T - 6);
      chk("R7", "still hot before timeout", st_d, 1);
      chk("R10", "up still hot before timeout", st_u, 1);
      tick(1);
      chk("R7", "down timeout exit", st_d, 2);
      chk("R7", "up timeout exit", st_u, 2);
      chk("R9", "timeout pulse", ex_d, 1);
      tick(1);
      chk("R9", "timeout pulse single", ex_u, 0);
      chk("R4", "link_up stays low", lu_d, 0);

      // hold past the pair
      hold_req = 1'b1;
      enter();
      send(1, 1, 1);
      send(1, 1, 1);
      tick(2 * T);
      chk("R5", "hold keeps down hot", st_d, 1);
      chk("R5", "hold keeps tx", tx_d, 1);
      chk("R5", "hold keeps up hot", st_u, 1);
      hold_req = 1'b0;
      @(negedge clk);
      chk("R6", "down exit on hold release", st_d, 2);
      tick(T - 1);
      chk("R7", "up waits after hold", st_u, 1);
      tick(1);
      chk("R7", "up exit after hold", st_u, 2);

      // upstream restart on repeated pairs
      tick(2);
      enter();
      tick(8);
      send(1, 1, 1);
      send(1, 1, 1);
      chk("R6", "down exit on pair", st_d, 2);
      tick(T - 4);
      send(1, 1, 1);
      send(1, 1, 1);
      tick(T);
      chk("R8", "up timer restarted", st_u, 1);
      tick(1);
      chk("R8", "up exit after last pair", st_u, 2);
      tick(3);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule